// File: doc/BRIEF.md
# Dual-Mode Interval and Seconds Timer

This block is a memory-mapped timer peripheral. Software programs it through a single-cycle register port and gets back one level interrupt and one single-cycle conversion-start pulse for an ADC. A configuration register picks one of two operating styles. In countdown style a 32-bit counter is loaded from a programmable interval, counts down once per clock, and signals a timeout. It either stops itself after the first timeout or reloads and repeats. In seconds style a 32-bit counter advances once per second, as derived from the clock by an internal divider, and wraps back to zero once it would pass a programmable limit.

Timeouts and wraps set bits in a raw status register. A mask register selects which raw bits drive the interrupt, a masked-status view returns the AND of the two, and a clear register drops any raw bit written as one. The interval and limit registers are each split into two 16-bit halves. A write to the low-half address also fills the upper half when the configuration value is below 4, and its read returns the joined value under the same condition.

Top module: `dual_mode_timer`

## Requirements
- R1: After reset every register reads 0, `irq` is low and `adc_trig` is low.
- R2: A read (`bus_valid`=1, `bus_write`=0) returns its data on `bus_rdata` one cycle later, and `bus_rdata` holds it until the next read. Offsets are: config 0x00 (3 bits), mode A 0x04 (4 bits), mode B 0x08 (4 bits), control 0x0C (16 bits), mask 0x18, raw status 0x1C, masked status 0x20, clear 0x24, interval 0x28/0x2C, limit 0x30/0x34 and counter value 0x48. The clear offset and unmapped offsets read 0.
- R3: A mask write keeps only the bits in 0x77. `irq` is high exactly when (raw AND mask) is nonzero, and offset 0x20 reads that AND. Raw bit 3 is therefore never able to raise `irq`.
- R4: Writing the clear register drops each raw status bit written as 1 and leaves the others. A status bit set in the same cycle survives the clear.
- R5: A write to 0x28 stores bits 15:0 in the low half and, only if config < 4, bits 31:16 in the high half. A write to 0x2C stores bits 15:0 in the high half. A read of 0x28 returns {high, low} when config < 4 and {16'h0, low} otherwise, and a read of 0x2C returns the high half. Offsets 0x30/0x34 follow the same rule for the limit.
- R6: With config 0, a write that changes control bit 0 from 0 to 1 loads the counter with the 32-bit interval L. The first timeout sets raw bit 0 on the (L+1)-th clock edge after the write edge.
- R7: At each timeout with control bit 5 set, `adc_trig` is high for exactly that one cycle. With bit 5 clear it stays low.
- R8: If mode A bit 0 is 1, a timeout clears control bit 0 and no further timeouts occur. If it is 0, timeouts repeat every L+1 cycles.
- R9: Writing control bit 0 from 1 to 0 stops the timer, and no further timeouts follow.
- R10: With config 1 and control bit 0 set, the seconds counter advances every TICK_CYCLES clocks, first at TICK_CYCLES edges after the enabling write. A step that would exceed the 32-bit limit gives 0 instead, and each step that yields 0 sets raw bit 3.
- R11: Offset 0x48 reads the seconds counter when config is 1 and 0 for any other config.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after a read |
| irq | output | 1 | Level interrupt, OR of masked status |
| adc_trig | output | 1 | One-cycle pulse on a countdown timeout |

## Verification
The hardest situation to reach from the ports is the seconds-counter wrap. It needs the config switched while the timer is disabled, a 32-bit limit written through the shared low-half address, and a full divider period per step. The bench builds the block with a short divider period and a limit of 2, enables it, and reads the counter at chosen times around the first, second and wrapping steps. It then confirms that raw bit 3 appears while the masked view and `irq` stay at zero because that bit lies outside the mask. The countdown timing is pinned by sampling `adc_trig` in the cycle just before and the cycle of the predicted timeout.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
  localparam int unsigned OFS_CFG    = 'h00;
  localparam int unsigned OFS_MODE_A = 'h04;
  localparam int unsigned OFS_MODE_B = 'h08;
  localparam int unsigned OFS_CTRL   = 'h0C;
  localparam int unsigned OFS_MASK   = 'h18;
  localparam int unsigned OFS_RAW    = 'h1C;
  localparam int unsigned OFS_MSTAT  = 'h20;
  localparam int unsigned OFS_CLEAR  = 'h24;
  localparam int unsigned OFS_IVL_LO = 'h28;
  localparam int unsigned OFS_IVL_HI = 'h2C;
  localparam int unsigned OFS_LIM_LO = 'h30;
  localparam int unsigned OFS_LIM_HI = 'h34;
  localparam int unsigned OFS_VALUE  = 'h48;

  localparam int unsigned CFG_W  = 3;
  localparam int unsigned MODE_W = 4;
  localparam int unsigned CTRL_W = 16;
  localparam int unsigned STAT_W = 8;

  localparam logic [STAT_W-1:0] MASK_KEEP = 8'h77;

  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_TRIG_BIT = 5;
  localparam int unsigned STAT_TO_BIT   = 0;
  localparam int unsigned STAT_WRAP_BIT = 3;

  typedef enum logic [CFG_W-1:0] {
    CFG_COUNTDOWN = 3'd0,
    CFG_SECONDS   = 3'd1
  } cfg_style_e;
endpackage

// File: rtl/dmt_secdiv.sv
module dmt_secdiv #(
  parameter int unsigned TICK_CYCLES = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic strobe
);
  localparam int unsigned DIV_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_CYCLES - 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic             div_en;

  assign strobe = run && !restart && (div_q == LAST);
  assign div_en = restart || run;

  always_comb begin
    div_d = div_q;
    if (restart) begin
      div_d = '0;
    end else if (run) begin
      div_d = (div_q == LAST) ? '0 : div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (div_en) begin
      div_q <= div_d;
    end
  end
endmodule

// File: rtl/dmt_engine.sv
module dmt_engine #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              start,
  input  logic              style_cd,
  input  logic              style_sec,
  input  logic              trig_en,
  input  logic [DATA_W-1:0] interval,
  input  logic [DATA_W-1:0] limit,
  input  logic              sec_strobe,
  output logic              expire,
  output logic              trig,
  output logic              wrap_zero,
  output logic [DATA_W-1:0] sec_count
);
  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic [DATA_W-1:0] sec_q, sec_d, sec_inc;
  logic              trig_q, trig_d;
  logic              cnt_en, sec_step;

  assign expire   = en && style_cd && (cnt_q == '0);
  assign sec_step = en && style_sec && sec_strobe;
  assign sec_inc  = sec_q + 1'b1;
  assign cnt_en   = start || (en && style_cd);

  always_comb begin
    cnt_d = cnt_q;
    if (start || expire) begin
      cnt_d = interval;
    end else if (en && style_cd) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_comb begin
    sec_d = (sec_inc > limit) ? '0 : sec_inc;
  end

  assign trig_d    = expire && trig_en;
  assign wrap_zero = sec_step && (sec_d == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
    end else if (sec_step) begin
      sec_q <= sec_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
    end else begin
      trig_q <= trig_d;
    end
  end

  assign trig      = trig_q;
  assign sec_count = sec_q;
endmodule

// File: rtl/dmt_regs.sv
module dmt_regs
  import dmt_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              expire,
  input  logic              wrap_zero,
  input  logic [DATA_W-1:0] sec_count,
  output logic              en,
  output logic              start,
  output logic              style_cd,
  output logic              style_sec,
  output logic              trig_en,
  output logic              oneshot,
  output logic [DATA_W-1:0] interval,
  output logic [DATA_W-1:0] limit,
  output logic [STAT_W-1:0] raw_stat,
  output logic [STAT_W-1:0] mask_stat,
  output logic              irq
);
  localparam int unsigned HALF_W = DATA_W / 2;

  logic [CFG_W-1:0]  cfg_q, cfg_d;
  logic [MODE_W-1:0] mode_a_q, mode_a_d, mode_b_q, mode_b_d;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [STAT_W-1:0] mask_q, mask_d, raw_q, raw_d;
  logic [HALF_W-1:0] ivl_lo_q, ivl_lo_d, ivl_hi_q, ivl_hi_d;
  logic [HALF_W-1:0] lim_lo_q, lim_lo_d, lim_hi_q, lim_hi_d;
  logic [DATA_W-1:0] rdata_q, rd_mux;
  logic              wr, rd, ctrl_wr, wide_cfg;
  logic [STAT_W-1:0] clr_bits, set_bits, masked;

  assign wr       = bus_valid && bus_write;
  assign rd       = bus_valid && !bus_write;
  assign ctrl_wr  = wr && (bus_addr == ADDR_W'(OFS_CTRL));
  assign wide_cfg = (cfg_q < CFG_W'(4));
  assign masked   = raw_q & mask_q;

  assign clr_bits = (wr && (bus_addr == ADDR_W'(OFS_CLEAR))) ? bus_wdata[STAT_W-1:0] : '0;

  always_comb begin
    set_bits = '0;
    set_bits[STAT_TO_BIT]   = expire;
    set_bits[STAT_WRAP_BIT] = wrap_zero;
  end

  // Next state of the writable registers
  always_comb begin
    cfg_d    = cfg_q;
    mode_a_d = mode_a_q;
    mode_b_d = mode_b_q;
    ctrl_d   = ctrl_q;
    mask_d   = mask_q;
    ivl_lo_d = ivl_lo_q;
    ivl_hi_d = ivl_hi_q;
    lim_lo_d = lim_lo_q;
    lim_hi_d = lim_hi_q;
    if (expire && mode_a_q[0] && !ctrl_wr) begin
      ctrl_d[CTRL_EN_BIT] = 1'b0;
    end
    if (wr) begin
      case (bus_addr)
        ADDR_W'(OFS_CFG):    cfg_d    = bus_wdata[CFG_W-1:0];
        ADDR_W'(OFS_MODE_A): mode_a_d = bus_wdata[MODE_W-1:0];
        ADDR_W'(OFS_MODE_B): mode_b_d = bus_wdata[MODE_W-1:0];
        ADDR_W'(OFS_CTRL):   ctrl_d   = bus_wdata[CTRL_W-1:0];
        ADDR_W'(OFS_MASK):   mask_d   = bus_wdata[STAT_W-1:0] & MASK_KEEP;
        ADDR_W'(OFS_IVL_LO): begin
          ivl_lo_d = bus_wdata[HALF_W-1:0];
          if (wide_cfg) ivl_hi_d = bus_wdata[DATA_W-1:HALF_W];
        end
        ADDR_W'(OFS_IVL_HI): ivl_hi_d = bus_wdata[HALF_W-1:0];
        ADDR_W'(OFS_LIM_LO): begin
          lim_lo_d = bus_wdata[HALF_W-1:0];
          if (wide_cfg) lim_hi_d = bus_wdata[DATA_W-1:HALF_W];
        end
        ADDR_W'(OFS_LIM_HI): lim_hi_d = bus_wdata[HALF_W-1:0];
        default: ;
      endcase
    end
  end

  // Status: a set in the same cycle wins over a clear
  assign raw_d = (raw_q & ~clr_bits) | set_bits;

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADDR_W'(OFS_CFG):    rd_mux = DATA_W'(cfg_q);
      ADDR_W'(OFS_MODE_A): rd_mux = DATA_W'(mode_a_q);
      ADDR_W'(OFS_MODE_B): rd_mux = DATA_W'(mode_b_q);
      ADDR_W'(OFS_CTRL):   rd_mux = DATA_W'(ctrl_q);
      ADDR_W'(OFS_MASK):   rd_mux = DATA_W'(mask_q);
      ADDR_W'(OFS_RAW):    rd_mux = DATA_W'(raw_q);
      ADDR_W'(OFS_MSTAT):  rd_mux = DATA_W'(masked);
      ADDR_W'(OFS_IVL_LO): rd_mux = {wide_cfg ? ivl_hi_q : '0, ivl_lo_q};
      ADDR_W'(OFS_IVL_HI): rd_mux = DATA_W'(ivl_hi_q);
      ADDR_W'(OFS_LIM_LO): rd_mux = {wide_cfg ? lim_hi_q : '0, lim_lo_q};
      ADDR_W'(OFS_LIM_HI): rd_mux = DATA_W'(lim_hi_q);
      ADDR_W'(OFS_VALUE):  rd_mux = (cfg_q == CFG_SECONDS) ? sec_count : '0;
      default:             rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      mode_a_q <= '0;
      mode_b_q <= '0;
      ctrl_q   <= '0;
      mask_q   <= '0;
      raw_q    <= '0;
      ivl_lo_q <= '0;
      ivl_hi_q <= '0;
      lim_lo_q <= '0;
      lim_hi_q <= '0;
    end else begin
      cfg_q    <= cfg_d;
      mode_a_q <= mode_a_d;
      mode_b_q <= mode_b_d;
      ctrl_q   <= ctrl_d;
      mask_q   <= mask_d;
      raw_q    <= raw_d;
      ivl_lo_q <= ivl_lo_d;
      ivl_hi_q <= ivl_hi_d;
      lim_lo_q <= lim_lo_d;
      lim_hi_q <= lim_hi_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd) begin
      rdata_q <= rd_mux;
    end
  end

  assign bus_rdata = rdata_q;
  assign en        = ctrl_q[CTRL_EN_BIT];
  assign start     = ctrl_wr && !ctrl_q[CTRL_EN_BIT] && bus_wdata[CTRL_EN_BIT];
  assign style_cd  = (cfg_q == CFG_COUNTDOWN);
  assign style_sec = (cfg_q == CFG_SECONDS);
  assign trig_en   = ctrl_q[CTRL_TRIG_BIT];
  assign oneshot   = mode_a_q[0];
  assign interval  = {ivl_hi_q, ivl_lo_q};
  assign limit     = {lim_hi_q, lim_lo_q};
  assign raw_stat  = raw_q;
  assign mask_stat = mask_q;
  assign irq       = |masked;
endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer
  import dmt_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned TICK_CYCLES = 50_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              adc_trig
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              en, start, style_cd, style_sec, trig_en, oneshot;
  logic              expire, wrap_zero, sec_strobe;
  logic [DATA_W-1:0] interval, limit, sec_count;
  logic [STAT_W-1:0] raw_stat, mask_stat;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  dmt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .expire    (expire),
    .wrap_zero (wrap_zero),
    .sec_count (sec_count),
    .en        (en),
    .start     (start),
    .style_cd  (style_cd),
    .style_sec (style_sec),
    .trig_en   (trig_en),
    .oneshot   (oneshot),
    .interval  (interval),
    .limit     (limit),
    .raw_stat  (raw_stat),
    .mask_stat (mask_stat),
    .irq       (irq)
  );

  dmt_secdiv #(.TICK_CYCLES(TICK_CYCLES)) u_div (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .run     (en && style_sec),
    .restart (start),
    .strobe  (sec_strobe)
  );

  dmt_engine #(.DATA_W(DATA_W)) u_eng (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .en         (en),
    .start      (start),
    .style_cd   (style_cd),
    .style_sec  (style_sec),
    .trig_en    (trig_en),
    .interval   (interval),
    .limit      (limit),
    .sec_strobe (sec_strobe),
    .expire     (expire),
    .trig       (adc_trig),
    .wrap_zero  (wrap_zero),
    .sec_count  (sec_count)
  );
endmodule

// File: rtl/dmt_checker.sv
module dmt_checker
  import dmt_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic              adc_trig,
  input logic              expire,
  input logic              oneshot,
  input logic              en,
  input logic              sec_step,
  input logic [DATA_W-1:0] sec_count,
  input logic [DATA_W-1:0] limit,
  input logic [STAT_W-1:0] raw_stat,
  input logic [STAT_W-1:0] mask_stat
);
  logic ctrl_wr;
  assign ctrl_wr = bus_valid && bus_write && (bus_addr == ADDR_W'(OFS_CTRL));

  assert_mask_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr == ADDR_W'(OFS_MASK))
      |=> ((bus_rdata & ~DATA_W'(MASK_KEEP)) == '0));

  assert_clear_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr == ADDR_W'(OFS_CLEAR)) |=> (bus_rdata == '0));

  assert_no_irq_unmasked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_stat == '0) |-> !irq);

  assert_trig_has_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig |-> raw_stat[STAT_TO_BIT]);

  assert_oneshot_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && oneshot && !ctrl_wr) |=> !en);

  assert_sec_within_limit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sec_step |=> (sec_count <= $past(limit)));
endmodule

bind dual_mode_timer dmt_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .adc_trig  (adc_trig),
  .expire    (expire),
  .oneshot   (oneshot),
  .en        (en),
  .sec_step  (en && style_sec && sec_strobe),
  .sec_count (sec_count),
  .limit     (limit),
  .raw_stat  (raw_stat),
  .mask_stat (mask_stat)
);

// File: tb/dual_mode_timer_bench.sv
module dual_mode_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICKS      = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, adc_trig;

  int checks = 0;
  int fails  = 0;
  int trig_cnt = 0;
  logic rd_cap = 1'b0;
  logic done = 1'b0;

  typedef struct { logic [31:0] exp; string tag; } exp_t;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_mode_timer #(.ADDR_W(8), .DATA_W(32), .TICK_CYCLES(TICKS)) u_dual_mode_timer (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .adc_trig(adc_trig)
  );

  // Monitor: capture read strobes at the edge, compare away from it
  always @(posedge clk) rd_cap <= bus_valid && !bus_write;

  always @(negedge clk) begin
    if (adc_trig) trig_cnt++;
    if (rd_cap) begin
      if (sb_q.size() == 0) begin
        fails++;
        $display("FAIL scoreboard: read data 0x%08h with no expected item", bus_rdata);
      end else begin
        exp_t it;
        it = sb_q.pop_front();
        checks++;
        if (bus_rdata !== it.exp)
          begin fails++; $display("FAIL %s: read 0x%08h expected 0x%08h", it.tag, bus_rdata, it.exp); end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    exp_t it;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] e, input string tag);
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, e);
    end
  endtask

  initial begin
    int snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk(irq, 0, "R1 irq after reset");
    chk(adc_trig, 0, "R1 trig after reset");
    rd(8'h00, 0, "R1 config");
    rd(8'h0C, 0, "R1 control");
    rd(8'h1C, 0, "R1 raw status");
    rd(8'h30, 0, "R1 limit");

    // R3 mask keeps 0x77
    wr(8'h18, 32'hFF);
    rd(8'h18, 32'h77, "R3 mask write filtered");

    // R5 split halves
    wr(8'h28, 32'h0003_0005);
    rd(8'h28, 32'h0003_0005, "R5 interval joined");
    rd(8'h2C, 32'h0000_0003, "R5 interval high half");
    wr(8'h00, 32'h4);
    wr(8'h28, 32'hAAAA_1111);
    rd(8'h28, 32'h0000_1111, "R5 narrow config read");
    rd(8'h2C, 32'h0000_0003, "R5 high half untouched");
    wr(8'h34, 32'h0000_0009);
    rd(8'h34, 32'h0000_0009, "R5 limit high half");
    wr(8'h00, 32'h0);
    rd(8'h30, 32'h0009_0000, "R5 limit joined");

    // R6 R7 R8 one-shot countdown, interval 4
    wr(8'h28, 32'h4);
    wr(8'h04, 32'h1);
    wr(8'h18, 32'h01);
    snap = trig_cnt;
    wr(8'h0C, 32'h21);
    idle(4);
    chk(adc_trig, 0, "R6 no timeout before L+1 edges");
    idle(1);
    chk(adc_trig, 1, "R6 R7 timeout pulse at L+1 edges");
    idle(1);
    chk(adc_trig, 0, "R7 pulse lasts one cycle");
    idle(20);
    chk(trig_cnt - snap, 1, "R8 one-shot fires once");
    rd(8'h0C, 32'h20, "R8 one-shot clears enable");
    rd(8'h1C, 32'h01, "R6 raw timeout bit");
    rd(8'h20, 32'h01, "R3 masked status");
    chk(irq, 1, "R3 irq from masked status");

    // R4 clear
    wr(8'h24, 32'h1);
    rd(8'h1C, 32'h00, "R4 raw cleared");
    rd(8'h24, 32'h00, "R2 clear register reads zero");
    chk(irq, 0, "R4 irq dropped after clear");

    // R8 periodic, interval 2 -> period 3; R9 stop
    wr(8'h28, 32'h2);
    wr(8'h04, 32'h0);
    snap = trig_cnt;
    wr(8'h0C, 32'h21);
    idle(31);
    chk(trig_cnt - snap, 10, "R8 periodic count over 30 edges");
    wr(8'h0C, 32'h20);
    snap = trig_cnt;
    idle(20);
    chk(trig_cnt - snap, 0, "R9 no timeouts after disable");

    // R7 trigger disabled
    snap = trig_cnt;
    wr(8'h0C, 32'h01);
    idle(12);
    chk(trig_cnt - snap, 0, "R7 no pulse with trigger bit clear");
    wr(8'h0C, 32'h00);
    rd(8'h1C, 32'h01, "R7 timeout still recorded");

    // R10 R11 seconds counter, limit 2
    wr(8'h24, 32'hFF);
    wr(8'h18, 32'h77);
    wr(8'h00, 32'h1);
    wr(8'h30, 32'h2);
    wr(8'h0C, 32'h01);
    idle(12);
    rd(8'h48, 32'd1, "R10 first step");
    idle(10);
    rd(8'h48, 32'd2, "R10 second step");
    idle(10);
    rd(8'h48, 32'd0, "R10 wrap past limit");
    rd(8'h1C, 32'h08, "R10 wrap status bit 3");
    rd(8'h20, 32'h00, "R3 bit 3 never masked in");
    chk(irq, 0, "R3 no irq from bit 3");
    wr(8'h24, 32'h01);
    rd(8'h1C, 32'h08, "R4 unwritten bit kept");
    wr(8'h0C, 32'h00);
    wr(8'h00, 32'h0);
    rd(8'h48, 32'h0, "R11 value reads zero in countdown config");
    rd(8'h50, 32'h0, "R2 unmapped offset");

    idle(3);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule